// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer ALU

This block is the combinational integer execution unit of a 32-bit RISC core. A 4-bit operation code picks one of thirteen functions. The functions are bitwise logic, add and subtract, left, logical right and arithmetic right shifts, inversion, signed and unsigned set-less-than, constant load and upper-half load. The result settles within the same cycle, with no internal state.

The second operand has two possible sources. The caller either passes a register value, or asks the unit to sign-extend a 16-bit constant taken from the instruction word. The upper-half load is the exception: it always takes the raw 16-bit constant, puts it in the high half of the result, and keeps the low half of operand A. Codes 1000, 1001 and 1111 are reserved and give zero.

Top module: `alu32_core`

## Requirements
- R1: Code 0000 gives A OR B, code 0001 gives A AND B, and code 0010 gives A XOR B, bit by bit.
- R2: Code 0011 gives A + B and code 0100 gives A - B. Both wrap modulo 2^32 and report no carry.
- R3: Code 0101 shifts A left and code 0110 shifts A right, filling with zeros. The shift amount is B[4:0] only, and B[31:5] has no effect on the result.
- R4: Code 1110 shifts A right by B[4:0] and fills the vacated bits with copies of A[31].
- R5: Code 0111 gives the bitwise inverse of A, and operand B has no effect on the result.
- R6: Code 1010 gives 32'd1 when A < B as two's-complement values, and 32'd0 otherwise.
- R7: Code 1011 gives 32'd1 when A < B as unsigned values, and 32'd0 otherwise.
- R8: Code 1100 gives operand B unchanged. In constant form this is the sign-extended constant.
- R9: Code 1101 gives {imm_i, A[15:0]}. It uses the raw constant in either operand form.
- R10: Reserved codes 1000, 1001 and 1111 give 32'd0 for any operands.
- R11: When use_imm_i is 1, operand B is {{16{imm_i[15]}}, imm_i} and b_reg_i is ignored. When use_imm_i is 0, operand B is b_reg_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A |
| b_reg_i | input | 32 | Register value for operand B |
| imm_i | input | 16 | Instruction constant |
| use_imm_i | input | 1 | 1 selects the sign-extended constant as operand B |
| result_o | output | 32 | Result |

## Verification
The logic codes are driven with complementary and overlapping bit patterns, so that a swapped operation shows as a mismatch. Add and subtract are tried across the wrap point and on operands whose lower bits carry into the upper half. The shifts use amounts 0, 1, 16 and 31, and also B values with the upper bits set, which separates a 5-bit amount from a wider one. Arithmetic right shift is driven with both signs of A. Both compares are fed operand pairs of opposite sign, where signed and unsigned order disagree, and pairs of equal values to test the strict boundary. The constant forms use both signs of the constant, which separates sign extension from the raw constant used by the upper-half load.

// File: rtl/alu32_pkg.sv
`timescale 1ns/1ps
package alu32_pkg;
  typedef enum logic [3:0] {
    OP_OR    = 4'b0000,
    OP_AND   = 4'b0001,
    OP_XOR   = 4'b0010,
    OP_ADD   = 4'b0011,
    OP_SUB   = 4'b0100,
    OP_SHL   = 4'b0101,
    OP_SHR   = 4'b0110,
    OP_NOT   = 4'b0111,
    OP_RSV8  = 4'b1000,
    OP_RSV9  = 4'b1001,
    OP_SLT   = 4'b1010,
    OP_SLTU  = 4'b1011,
    OP_LOAD  = 4'b1100,
    OP_LDHI  = 4'b1101,
    OP_SRA   = 4'b1110,
    OP_RSVF  = 4'b1111
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_ARITH = 2'd2
  } shift_kind_e;
endpackage

// File: rtl/alu_operand_sel.sv
`timescale 1ns/1ps
module alu_operand_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] b_reg_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  output logic [DATA_W-1:0] b_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign b_o     = use_imm_i ? imm_ext : b_reg_i;

  always_comb begin
    if (!use_imm_i) begin
      p_reg_pass_r11: assert (b_o == b_reg_i) else $error("operand B not register");
    end else begin
      p_sext_low_r11: assert (b_o[IMM_W-1:0] == imm_i) else $error("constant low bits");
    end
  end
endmodule

// File: rtl/alu_shifter.sv
`timescale 1ns/1ps
module alu_shifter
  import alu32_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [SH_W-1:0]   amt_i,
  input  shift_kind_e       kind_i,
  output logic [DATA_W-1:0] res_o
);
  logic                     fill;
  logic [DATA_W-1:0]        a_rev;
  logic [DATA_W-1:0]        src;
  logic [DATA_W-1:0]        out_rev;
  logic [DATA_W-1:0]        stage [SH_W+1];

  // left shift reuses the right-shift stages on a bit-reversed word
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign a_rev[i]   = a_i[DATA_W-1-i];
    assign out_rev[i] = stage[SH_W][DATA_W-1-i];
  end

  assign fill     = (kind_i == SH_ARITH) & a_i[DATA_W-1];
  assign src      = (kind_i == SH_LEFT) ? a_rev : a_i;
  assign stage[0] = src;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stage[k+1] = amt_i[k] ? {{D{fill}}, stage[k][DATA_W-1:D]} : stage[k];
  end

  assign res_o = (kind_i == SH_LEFT) ? out_rev : stage[SH_W];

  always_comb begin
    if (amt_i == '0) begin
      p_zero_amt_r3: assert (res_o == a_i) else $error("zero shift altered A");
    end
    if (kind_i == SH_ARITH && amt_i != '0) begin
      p_sign_fill_r4: assert (res_o[DATA_W-1] == a_i[DATA_W-1]) else $error("sign fill");
    end
  end
endmodule

// File: rtl/alu_arith_unit.sv
`timescale 1ns/1ps
module alu_arith_unit
  import alu32_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              lt_s_o,
  output logic              lt_u_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  // one adder serves add, subtract and both compares
  assign b_eff  = sub_i ? ~b_i : b_i;
  assign wide   = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
  assign sum_o  = wide[DATA_W-1:0];
  assign lt_u_o = ~wide[DATA_W];
  assign lt_s_o = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : wide[MSB];

  always_comb begin
    if (sub_i && a_i == b_i) begin
      p_eq_not_lt_r6: assert (!lt_s_o && !lt_u_o) else $error("equal flagged less");
    end
    if (sub_i) begin
      p_sub_inverse_r2: assert (sum_o + b_i == a_i) else $error("difference wrong");
    end
  end
endmodule

// File: rtl/alu32_core.sv
`timescale 1ns/1ps
module alu32_core
  import alu32_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int LO_W  = DATA_W - IMM_W
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_reg_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  output logic [DATA_W-1:0] result_o
);
  alu_op_e           op;
  logic [DATA_W-1:0] b_op;
  logic [DATA_W-1:0] sh_res;
  logic [DATA_W-1:0] sum;
  logic              lt_s;
  logic              lt_u;
  logic              use_sub;
  shift_kind_e       sh_kind;

  assign op      = alu_op_e'(op_i);
  assign use_sub = (op != OP_ADD);

  always_comb begin
    unique case (op)
      OP_SHL:  sh_kind = SH_LEFT;
      OP_SRA:  sh_kind = SH_ARITH;
      default: sh_kind = SH_RIGHT;
    endcase
  end

  alu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_bsel (
    .b_reg_i  (b_reg_i),
    .imm_i    (imm_i),
    .use_imm_i(use_imm_i),
    .b_o      (b_op)
  );

  alu_shifter #(.DATA_W(DATA_W)) u_shift (
    .a_i   (a_i),
    .amt_i (b_op[SH_W-1:0]),
    .kind_i(sh_kind),
    .res_o (sh_res)
  );

  alu_arith_unit #(.DATA_W(DATA_W)) u_arith (
    .a_i   (a_i),
    .b_i   (b_op),
    .sub_i (use_sub),
    .sum_o (sum),
    .lt_s_o(lt_s),
    .lt_u_o(lt_u)
  );

  always_comb begin
    unique case (op)
      OP_OR:                    result_o = a_i | b_op;
      OP_AND:                   result_o = a_i & b_op;
      OP_XOR:                   result_o = a_i ^ b_op;
      OP_ADD, OP_SUB:           result_o = sum;
      OP_SHL, OP_SHR, OP_SRA:   result_o = sh_res;
      OP_NOT:                   result_o = ~a_i;
      OP_SLT:                   result_o = {{(DATA_W-1){1'b0}}, lt_s};
      OP_SLTU:                  result_o = {{(DATA_W-1){1'b0}}, lt_u};
      OP_LOAD:                  result_o = b_op;
      OP_LDHI:                  result_o = {imm_i, a_i[LO_W-1:0]};
      OP_RSV8, OP_RSV9, OP_RSVF: result_o = '0;
      default:                  result_o = '0;
    endcase
  end

  always_comb begin
    if (op == OP_RSV8 || op == OP_RSV9 || op == OP_RSVF) begin
      p_reserved_zero_r10: assert (result_o == '0) else $error("reserved code nonzero");
    end
    if (op == OP_SLT || op == OP_SLTU) begin
      p_slt_bool_r7: assert (result_o[DATA_W-1:1] == '0) else $error("compare not boolean");
    end
    if (op == OP_LDHI) begin
      p_ldhi_keep_r9: assert (result_o[LO_W-1:0] == a_i[LO_W-1:0]) else $error("low half lost");
    end
    if (op == OP_ADD) begin
      p_add_inverse_r2: assert (result_o - b_op == a_i) else $error("sum wrong");
    end
    if (op == OP_NOT) begin
      p_not_inv_r5: assert ((result_o ^ a_i) == '1) else $error("not wrong");
    end
    if (op == OP_LOAD && use_imm_i) begin
      p_load_const_r8: assert (result_o[IMM_W-1:0] == imm_i) else $error("load const");
    end
  end
endmodule

// File: tb/alu32_core_test.sv
`timescale 1ns/1ps
module alu32_core_test;
  logic        clk = 1'b0;
  logic [3:0]  op;
  logic [31:0] a, breg;
  logic [15:0] imm;
  logic        use_imm;
  logic [31:0] result;
  int          n_vec  = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  alu32_core uut (
    .op_i     (op),
    .a_i      (a),
    .b_reg_i  (breg),
    .imm_i    (imm),
    .use_imm_i(use_imm),
    .result_o (result)
  );

  function automatic logic [31:0] model(input logic [3:0] c, input logic [31:0] x,
                                        input logic [31:0] r, input logic [15:0] k,
                                        input logic u);
    logic [31:0] y;
    y = u ? {{16{k[15]}}, k} : r;
    case (c)
      4'b0000: return x | y;
      4'b0001: return x & y;
      4'b0010: return x ^ y;
      4'b0011: return x + y;
      4'b0100: return x - y;
      4'b0101: return x << y[4:0];
      4'b0110: return x >> y[4:0];
      4'b0111: return ~x;
      4'b1010: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'b1011: return (x < y) ? 32'd1 : 32'd0;
      4'b1100: return y;
      4'b1101: return {k, x[15:0]};
      4'b1110: return $unsigned($signed(x) >>> y[4:0]);
      default: return 32'd0;
    endcase
  endfunction

  task automatic apply(input logic [3:0] c, input logic [31:0] x, input logic [31:0] r,
                       input logic [15:0] k, input logic u, input string req);
    logic [31:0] exp;
    @(negedge clk);
    op = c; a = x; breg = r; imm = k; use_imm = u;
    #2;
    exp = model(c, x, r, k, u);
    n_vec++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h imm=%h u=%b: got %h expected %h",
               req, c, x, r, k, u, result, exp);
    end
  endtask

  task automatic t_idle();       // inputs at zero
    apply(4'b0000, 32'h0, 32'h0, 16'h0, 1'b0, "R1 idle");
  endtask

  task automatic t_logic();
    apply(4'b0000, 32'hF0F0_00FF, 32'h0F0F_0F00, 16'h0, 1'b0, "R1 or");
    apply(4'b0001, 32'hFFFF_0000, 32'h0FF0_0FF0, 16'h0, 1'b0, "R1 and");
    apply(4'b0010, 32'hAAAA_5555, 32'hFFFF_0000, 16'h0, 1'b0, "R1 xor");
  endtask

  task automatic t_addsub();
    apply(4'b0011, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, "R2 add wrap");
    apply(4'b0011, 32'h0000_FFFF, 32'h0000_0001, 16'h0, 1'b0, "R2 add carry");
    apply(4'b0100, 32'h0, 32'h1, 16'h0, 1'b0, "R2 sub wrap");
    apply(4'b0100, 32'h1234_5678, 32'h0, 16'hFFFF, 1'b1, "R2 sub const");
  endtask

  task automatic t_shift();
    apply(4'b0101, 32'h8000_0001, 32'd1, 16'h0, 1'b0, "R3 shl 1");
    apply(4'b0101, 32'h0000_ABCD, 32'hFFFF_FFF0, 16'h0, 1'b0, "R3 shl 16 high bits");
    apply(4'b0110, 32'h8000_0000, 32'd31, 16'h0, 1'b0, "R3 shr 31");
    apply(4'b0110, 32'hDEAD_BEEF, 32'h0000_0020, 16'h0, 1'b0, "R3 shr amount 0");
    apply(4'b1110, 32'h8000_0000, 32'd31, 16'h0, 1'b0, "R4 sra neg");
    apply(4'b1110, 32'h7F00_0000, 32'd4, 16'h0, 1'b0, "R4 sra pos");
    apply(4'b1110, 32'hF000_1234, 32'h0, 16'h0010, 1'b1, "R4 sra const 16");
  endtask

  task automatic t_not();
    apply(4'b0111, 32'h1234_5678, 32'hFFFF_FFFF, 16'h0, 1'b0, "R5 not");
    apply(4'b0111, 32'h1234_5678, 32'h0, 16'h8001, 1'b1, "R5 not const");
  endtask

  task automatic t_compare();
    apply(4'b1010, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, "R6 slt neg<pos");
    apply(4'b1010, 32'h5, 32'h5, 16'h0, 1'b0, "R6 slt equal");
    apply(4'b1010, 32'h1, 32'h0, 16'hFFFF, 1'b1, "R6 slt const -1");
    apply(4'b1011, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, "R7 sltu big");
    apply(4'b1011, 32'h1, 32'hFFFF_FFFF, 16'h0, 1'b0, "R7 sltu small");
    apply(4'b1011, 32'h7, 32'h7, 16'h0, 1'b0, "R7 sltu equal");
  endtask

  task automatic t_load();
    apply(4'b1100, 32'h0, 32'hCAFE_F00D, 16'h1234, 1'b0, "R8 load reg");
    apply(4'b1100, 32'h0, 32'hCAFE_F00D, 16'h8421, 1'b1, "R8 load neg const");
    apply(4'b1100, 32'h0, 32'hCAFE_F00D, 16'h7FFF, 1'b1, "R11 load pos const");
    apply(4'b1101, 32'hAAAA_5678, 32'h0, 16'h9ABC, 1'b1, "R9 ldhi neg const");
    apply(4'b1101, 32'hAAAA_5678, 32'h1111_1111, 16'h1234, 1'b0, "R9 ldhi reg form");
  endtask

  task automatic t_reserved();
    apply(4'b1000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 1'b0, "R10 code 1000");
    apply(4'b1001, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 1'b1, "R10 code 1001");
    apply(4'b1111, 32'h1234_5678, 32'h9ABC_DEF0, 16'h0, 1'b0, "R10 code 1111");
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    op = '0; a = '0; breg = '0; imm = '0; use_imm = 1'b0;
    t_idle();
    t_logic();
    t_addsub();
    t_shift();
    t_not();
    t_compare();
    t_load();
    t_reserved();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule